// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Priority Arbiter

This block selects, for a single CPU interface, the most urgent interrupt that may be delivered from a configurable set of interrupt lines (64 by default). For each line it receives an enable bit, a pending bit, a mask of target CPUs, a group bit and an 8-bit priority, all as flat input vectors. Priority storage and line state live outside the block. It also receives controller-wide group enables, this CPU's group enables, an enable that routes group 0 to the fast-interrupt line, a priority mask and the priority currently running on the CPU.

A balanced tree of compare nodes reduces all qualified lines to one winner in a single combinational pass. A small registered state machine then classifies that winner into one of four named states: `ST_QUIET` (nothing reported, ID 1023), `ST_HELD` (an ID is reported but not signalled), `ST_IRQ` (signalled on the normal interrupt line) and `ST_FIQ` (signalled on the fast interrupt line). The state register reloads every cycle from the current inputs, so any state can move to any other. A transition is named after its target state: *close* goes to `ST_QUIET`, *hold* to `ST_HELD`, *raise-irq* to `ST_IRQ` and *raise-fiq* to `ST_FIQ`. The block is meant to sit beside the interrupt state storage of a distributor and feed one CPU's interrupt pins.

Top module: `irq_pend_arbiter`

## Requirements
- R1: A smaller priority value is more urgent. The winner is the qualified line with the numerically smallest priority.
- R2: When two qualified lines have equal priority, the line with the lower ID wins.
- R3: A line qualifies only when its enable and pending bits are both set. It must also either have an ID below 32 (a private line) or have bit CPU_ID of its target mask set. Line k's target mask occupies bits k*CPU_COUNT to k*CPU_COUNT+CPU_COUNT-1 of `line_target`.
- R4: When no line qualifies, `pend_id` is 1023 and both interrupt outputs are low.
- R5: When `dist_grp_en` is 0, or `cpu_grp_en` is 0, `pend_id` is 1023 and both interrupt outputs are low, whatever the lines hold.
- R6: The winner is reported on `pend_id` only when its priority is strictly below `prio_mask`. Otherwise `pend_id` is 1023 and nothing is signalled.
- R7: A reported winner is signalled only when its priority, zero-extended to 9 bits, is strictly below `run_prio`. The value 256 means no interrupt is running.
- R8: A reported winner is signalled only when the enable for its group is set in both `dist_grp_en` and `cpu_grp_en`. Bit 0 enables group 0 and bit 1 enables group 1, and the group bit 0 means group 0.
- R9: A signalled group-0 winner drives `fiq_out` when `fiq_route_en` is 1, and `irq_out` otherwise. A signalled group-1 winner always drives `irq_out`.
- R10: `irq_out` and `fiq_out` are never high in the same cycle.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R12: A synchronous active-high reset sets `pend_id` to 1023 and drives both interrupt outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_enable | input | NUM_LINES | Per-line enable |
| line_pending | input | NUM_LINES | Per-line pending |
| line_target | input | NUM_LINES*CPU_COUNT | Per-line CPU target masks, line k at k*CPU_COUNT |
| line_group | input | NUM_LINES | Per-line group (0 or 1) |
| line_prio | input | NUM_LINES*8 | Per-line priority, line k at bits k*8+7:k*8 |
| dist_grp_en | input | 2 | Controller-wide enables, bit g for group g |
| cpu_grp_en | input | 2 | This CPU's enables, bit g for group g |
| fiq_route_en | input | 1 | Route group 0 to the fast interrupt line |
| prio_mask | input | 8 | Priority mask threshold |
| run_prio | input | 9 | Running priority, 256 when idle |
| pend_id | output | 10 | Reported winner ID, 1023 when none |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
A wrong tie-break or a missed qualification term shows as a wrong `pend_id` in the cycle after the stimulus, because the tree has no state of its own. A state register that has settled in the wrong state shows one cycle after the inputs that should have chosen the state: as a stray or missing pulse on `irq_out` or `fiq_out`, or as both high together. A stale ID register shows as a non-1023 ID beside a closed controller. Every scenario is therefore checked one edge after it is applied, and the next scenario starts from a different input pattern, so that a register holding an old value is caught.

// File: rtl/pend_arb_pkg.sv
package pend_arb_pkg;

    localparam int unsigned PRIO_W     = 8;
    localparam int unsigned RUN_W      = PRIO_W + 1;
    localparam int unsigned ID_W       = 10;
    localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;

    // one arbitration candidate travelling through the compare tree
    typedef struct packed {
        logic              valid;
        logic              grp;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_HELD  = 2'd1,
        ST_IRQ   = 2'd2,
        ST_FIQ   = 2'd3
    } sig_state_e;

endpackage

// File: rtl/pa_qualify.sv
module pa_qualify
    import pend_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 64,
    parameter int unsigned CPU_COUNT  = 2,
    parameter int unsigned CPU_ID     = 0,
    parameter int unsigned PRIV_LINES = 32
) (
    input  logic [NUM_LINES-1:0]           line_enable,
    input  logic [NUM_LINES-1:0]           line_pending,
    input  logic [NUM_LINES*CPU_COUNT-1:0] line_target,
    input  logic [NUM_LINES-1:0]           line_group,
    input  logic [NUM_LINES*PRIO_W-1:0]    line_prio,
    output cand_t                          cands [NUM_LINES]
);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        logic routed;
        if (k < PRIV_LINES) begin : g_priv
            assign routed = 1'b1;
        end else begin : g_shared
            assign routed = line_target[k*CPU_COUNT + CPU_ID];
        end
        assign cands[k].valid = line_enable[k] & line_pending[k] & routed;
        assign cands[k].grp   = line_group[k];
        assign cands[k].prio  = line_prio[k*PRIO_W +: PRIO_W];
        assign cands[k].id    = ID_W'(k);
    end

endmodule

// File: rtl/pa_node.sv
module pa_node
    import pend_arb_pkg::*;
(
    input  cand_t lo,
    input  cand_t hi,
    output cand_t win
);

    // lo carries the lower IDs: hi only wins when strictly more urgent
    logic take_hi;

    always_comb begin
        take_hi = hi.valid && (!lo.valid || (hi.prio < lo.prio));
        win     = take_hi ? hi : lo;
    end

endmodule

// File: rtl/pa_tree.sv
module pa_tree
    import pend_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64
) (
    input  cand_t cands [NUM_LINES],
    output cand_t best
);

    localparam int unsigned LEVELS = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int unsigned LEAVES = 1 << LEVELS;

    // heap layout: node i has children 2i (lower IDs) and 2i+1
    cand_t heap [1:2*LEAVES-1];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < NUM_LINES) begin : g_real
            assign heap[LEAVES + k] = cands[k];
        end else begin : g_pad
            assign heap[LEAVES + k] = '0;
        end
    end

    for (genvar i = 1; i < LEAVES; i++) begin : g_node
        pa_node u_node (
            .lo  (heap[2*i]),
            .hi  (heap[2*i + 1]),
            .win (heap[i])
        );
    end

    assign best = heap[1];

endmodule

// File: rtl/pa_signal_fsm.sv
module pa_signal_fsm
    import pend_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cand_t            best,
    input  logic [1:0]       dist_grp_en,
    input  logic [1:0]       cpu_grp_en,
    input  logic             fiq_route_en,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [RUN_W-1:0]  run_prio,
    output logic [ID_W-1:0]  pend_id,
    output logic             irq_out,
    output logic             fiq_out
);

    sig_state_e      state_q, state_d;
    logic [ID_W-1:0] id_q, id_d;

    logic open_path;
    logic below_mask;
    logic below_run;
    logic grp_on;

    always_comb begin
        open_path  = (|dist_grp_en) && (|cpu_grp_en);
        below_mask = best.valid && (best.prio < prio_mask);
        below_run  = {1'b0, best.prio} < run_prio;
        grp_on     = dist_grp_en[best.grp] && cpu_grp_en[best.grp];

        state_d = ST_QUIET;
        id_d    = NO_IRQ_ID;
        if (open_path && below_mask) begin
            id_d = best.id;
            if (!below_run || !grp_on) begin
                state_d = ST_HELD;                      // hold
            end else if (!best.grp && fiq_route_en) begin
                state_d = ST_FIQ;                       // raise-fiq
            end else begin
                state_d = ST_IRQ;                       // raise-irq
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET;
            id_q    <= NO_IRQ_ID;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        irq_out = 1'b0;
        fiq_out = 1'b0;
        pend_id = id_q;
        unique case (state_q)
            ST_QUIET: pend_id = NO_IRQ_ID;
            ST_HELD:  ;
            ST_IRQ:   irq_out = 1'b1;
            ST_FIQ:   fiq_out = 1'b1;
            default:  pend_id = NO_IRQ_ID;
        endcase
    end

endmodule

// File: rtl/irq_pend_arbiter.sv
module irq_pend_arbiter
    import pend_arb_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 64,
    parameter int unsigned CPU_COUNT  = 2,
    parameter int unsigned CPU_ID     = 0,
    parameter int unsigned PRIV_LINES = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_LINES-1:0]           line_enable,
    input  logic [NUM_LINES-1:0]           line_pending,
    input  logic [NUM_LINES*CPU_COUNT-1:0] line_target,
    input  logic [NUM_LINES-1:0]           line_group,
    input  logic [NUM_LINES*8-1:0]         line_prio,
    input  logic [1:0]                     dist_grp_en,
    input  logic [1:0]                     cpu_grp_en,
    input  logic                           fiq_route_en,
    input  logic [7:0]                     prio_mask,
    input  logic [8:0]                     run_prio,
    output logic [9:0]                     pend_id,
    output logic                           irq_out,
    output logic                           fiq_out
);

    cand_t cands [NUM_LINES];
    cand_t best;

    pa_qualify #(
        .NUM_LINES  (NUM_LINES),
        .CPU_COUNT  (CPU_COUNT),
        .CPU_ID     (CPU_ID),
        .PRIV_LINES (PRIV_LINES)
    ) u_qualify (
        .line_enable  (line_enable),
        .line_pending (line_pending),
        .line_target  (line_target),
        .line_group   (line_group),
        .line_prio    (line_prio),
        .cands        (cands)
    );

    pa_tree #(
        .NUM_LINES (NUM_LINES)
    ) u_tree (
        .cands (cands),
        .best  (best)
    );

    pa_signal_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .best         (best),
        .dist_grp_en  (dist_grp_en),
        .cpu_grp_en   (cpu_grp_en),
        .fiq_route_en (fiq_route_en),
        .prio_mask    (prio_mask),
        .run_prio     (run_prio),
        .pend_id      (pend_id),
        .irq_out      (irq_out),
        .fiq_out      (fiq_out)
    );

endmodule

// File: rtl/irq_pend_arbiter_chk.sv
module irq_pend_arbiter_chk #(
    parameter int unsigned NUM_LINES = 64
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] dist_grp_en,
    input logic [1:0] cpu_grp_en,
    input logic       fiq_route_en,
    input logic [8:0] run_prio,
    input logic [9:0] pend_id,
    input logic       irq_out,
    input logic       fiq_out
);

    assert_irq_fiq_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(irq_out && fiq_out));

    assert_closed_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ((dist_grp_en == 2'b00) || (cpu_grp_en == 2'b00))
        |=> (pend_id == 10'd1023) && !irq_out && !fiq_out);

    assert_signal_has_id_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_out || fiq_out) |-> (pend_id < 10'(NUM_LINES)));

    assert_no_id_no_signal_R4: assert property (@(posedge clk) disable iff (rst)
        (pend_id == 10'd1023) |-> (!irq_out && !fiq_out));

    assert_fiq_needs_route_R9: assert property (@(posedge clk) disable iff (rst)
        !fiq_route_en |=> !fiq_out);

    assert_run_zero_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (run_prio == 9'd0) |=> (!irq_out && !fiq_out));

    assert_reset_clears_R12: assert property (@(posedge clk)
        rst |=> (pend_id == 10'd1023) && !irq_out && !fiq_out);

endmodule

bind irq_pend_arbiter irq_pend_arbiter_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dist_grp_en  (dist_grp_en),
    .cpu_grp_en   (cpu_grp_en),
    .fiq_route_en (fiq_route_en),
    .run_prio     (run_prio),
    .pend_id      (pend_id),
    .irq_out      (irq_out),
    .fiq_out      (fiq_out)
);

// File: tb/irq_pend_arbiter_bench.sv
`timescale 1ns/1ps
module irq_pend_arbiter_bench;

    localparam int N    = 64;
    localparam int CPUS = 2;
    localparam int ME   = 0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    en, pend, grp;
    logic [N*CPUS-1:0] tgt;
    logic [N*8-1:0]  prio;
    logic [1:0]      dge, cge;
    logic            fen;
    logic [7:0]      pmask;
    logic [8:0]      rprio;
    logic [9:0]      pend_id;
    logic            irq_out, fiq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [9:0] exp_id_q  [$];
    logic       exp_irq_q [$];
    logic       exp_fiq_q [$];
    string      exp_tag_q [$];

    always #2.5 clk = ~clk;

    irq_pend_arbiter #(.NUM_LINES(N), .CPU_COUNT(CPUS), .CPU_ID(ME)) u_irq_pend_arbiter (
        .clk(clk), .rst(rst),
        .line_enable(en), .line_pending(pend), .line_target(tgt),
        .line_group(grp), .line_prio(prio),
        .dist_grp_en(dge), .cpu_grp_en(cge), .fiq_route_en(fen),
        .prio_mask(pmask), .run_prio(rprio),
        .pend_id(pend_id), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string tag, input logic [9:0] aid, input logic ai,
                         input logic af, input logic [9:0] eid, input logic ei,
                         input logic ef);
        n_checks++;
        if (aid !== eid || ai !== ei || af !== ef) begin
            n_fail++;
            $display("FAIL %s: got id=%0d irq=%0b fiq=%0b, expected id=%0d irq=%0b fiq=%0b",
                     tag, aid, ai, af, eid, ei, ef);
        end
    endtask

    // driver: computes the expected result from the requirements and queues it
    task automatic apply(input string tag);
        logic       found = 1'b0;
        int         bid   = 0;
        logic [7:0] bp    = 8'hFF;
        logic [9:0] eid   = 10'd1023;
        logic       ei    = 1'b0;
        logic       ef    = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (en[k] && pend[k] && (k < 32 || tgt[k*CPUS+ME])) begin
                if (!found || prio[k*8 +: 8] < bp) begin
                    found = 1'b1;
                    bid   = k;
                    bp    = prio[k*8 +: 8];
                end
            end
        end
        if (dge != 2'b00 && cge != 2'b00 && found && bp < pmask) begin
            eid = 10'(bid);
            if ({1'b0, bp} < rprio && dge[grp[bid]] && cge[grp[bid]]) begin
                if (!grp[bid] && fen) ef = 1'b1;
                else                  ei = 1'b1;
            end
        end
        exp_id_q.push_back(eid);
        exp_irq_q.push_back(ei);
        exp_fiq_q.push_back(ef);
        exp_tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: one edge after the driver, compare with the queued item (R11)
    always @(posedge clk) begin
        #1;
        if (exp_id_q.size() > 0) begin
            check(exp_tag_q.pop_front(), pend_id, irq_out, fiq_out,
                  exp_id_q.pop_front(), exp_irq_q.pop_front(), exp_fiq_q.pop_front());
            n_checks++;
            if (irq_out && fiq_out) begin
                n_fail++;
                $display("FAIL R10: got irq=1 fiq=1, expected at most one high");
            end
        end
    end

    task automatic baseline();
        en = '0; pend = '0; grp = '1; tgt = '0;
        for (int k = 0; k < N; k++) prio[k*8 +: 8] = 8'hA0;
        dge = 2'b11; cge = 2'b11; fen = 1'b0;
        pmask = 8'hFF; rprio = 9'h100;
    endtask

    task automatic arm(input int k, input logic [7:0] p);
        en[k] = 1'b1; pend[k] = 1'b1; tgt[k*CPUS+ME] = 1'b1;
        prio[k*8 +: 8] = p;
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected end of run");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        baseline();
        arm(7, 8'h10);
        repeat (3) @(negedge clk);
        // R12: reset state while inputs hold a deliverable line
        check("R12 reset", pend_id, irq_out, fiq_out, 10'd1023, 1'b0, 1'b0);
        rst = 1'b0;

        baseline();                               apply("R4 nothing qualifies");
        arm(40, 8'h50); arm(45, 8'h30);           apply("R1 smaller value wins");
        prio[40*8 +: 8] = 8'h30;                  apply("R2 tie lower id");
        baseline(); arm(40, 8'h10); en[40] = 1'b0; arm(45, 8'h30);
                                                  apply("R3 disabled skipped");
        baseline(); arm(50, 8'h10); tgt[50*CPUS+ME] = 1'b0; tgt[50*CPUS+1] = 1'b1;
        arm(45, 8'h30);                           apply("R3 other cpu target skipped");
        baseline(); arm(45, 8'h30); arm(5, 8'h20); tgt[5*CPUS+ME] = 1'b0;
                                                  apply("R3 private line needs no target");
        pend[5] = 1'b0;                           apply("R3 not pending skipped");
        dge = 2'b00;                              apply("R5 controller closed");
        dge = 2'b11; cge = 2'b00;                 apply("R5 cpu closed");
        cge = 2'b11; pmask = 8'h30;               apply("R6 equal to mask hidden");
        pmask = 8'h31;                            apply("R6 below mask shown");
        pmask = 8'hFF; rprio = 9'h030;            apply("R7 equal to running held");
        rprio = 9'h031;                           apply("R7 below running signalled");
        rprio = 9'h100; cge = 2'b01;              apply("R8 group1 off at cpu");
        cge = 2'b11; dge = 2'b01;                 apply("R8 group1 off globally");
        dge = 2'b11; grp[45] = 1'b0; fen = 1'b1;  apply("R9 group0 on fiq");
        fen = 1'b0;                               apply("R9 group0 on irq without routing");
        grp[45] = 1'b1; fen = 1'b1;               apply("R9 group1 ignores routing");
        baseline();                               apply("R11 clears next cycle");
        arm(63, 8'h00); arm(0, 8'h00);            apply("R2 id 0 beats 63");
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule